// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame should be kept, looking only at its 48-bit destination address. A frame parser upstream presents the address together with a one-cycle strobe. One cycle later the filter returns a verdict: an accept flag, a code that says why the frame was accepted, and the index of the exact-match slot when one was used. Frame parsing and FCS checking are done elsewhere.

The filter holds four exact-match station slots, a 64-bit hash table and four configuration bits. All of these are loaded through a simple synchronous register write port. The hash index is made by XOR-folding all 48 address bits down to 6 bits, and it selects one bit of the table. Copy-all mode accepts every frame. A no-broadcast bit blocks the all-ones address. Separate enables let multicast and unicast destinations be accepted through the hash table.

The control is a two-state machine. `ST_IDLE` means no verdict is being presented. `ST_REPORT` means a verdict is on the outputs. The transition *strobe* goes from either state to `ST_REPORT`. The transition *no strobe* goes from either state to `ST_IDLE`.

Top module: `dst_addr_filter`

## Requirements
- R1: `res_valid` is high in exactly the cycles that follow a cycle with `dst_valid` high, including back-to-back strobes. `accept`, `reason` and `match_slot` change only on a strobe and hold their values otherwise.
- R2: Register writes (`wr_en` high) are decoded by `wr_addr` as follows:
  - Address 2k holds bytes 0..3 of slot k, with byte 0 in bits 7:0.
  - Address 2k+1 holds bytes 4..5 of slot k in bits 15:0.
  - Address 8 is hash table bits 31:0, and address 9 is hash table bits 63:32.
  - Address 10 is the configuration: bit 0 copy-all, bit 1 no-broadcast, bit 2 multicast-hash enable, bit 3 unicast-hash enable.
  - A write takes effect for strobes in later cycles.
- R3: With copy-all set, every address is accepted with reason 4 (promiscuous).
- R4: The all-ones address is accepted with reason 2 (broadcast) unless no-broadcast is set, in which case it is rejected. Broadcast is decided before any slot or hash lookup.
- R5: An address equal to a slot's stored value is accepted with reason 1 (exact slot), and `match_slot` gives the slot index. When several slots match, the lowest index wins.
- R6: A slot holding all zeros is unused and never matches, so a zero destination is never accepted through a slot.
- R7: Address bit i is `dst_addr[i]`, which is bit (i mod 8) of byte (i div 8), with byte 0 sent first on the wire. Hash index bit k is the XOR of all address bits with i mod 6 = k. The index n selects bit n of {high word, low word}.
- R8: A multicast address (bit 0 set, not all ones) is accepted with reason 3 (hash) only when multicast-hash is enabled and its table bit is set. An all-ones table therefore passes every multicast address.
- R9: A unicast address (bit 0 clear) is accepted with reason 3 only when unicast-hash is enabled and its table bit is set.
- R10: An exact-slot match takes priority over the hash. `accept` is high exactly when `reason` is not 0 (none). With no match, the address is rejected with reason 0 and `match_slot` is 0.
- R11: After reset, all slots, the table and the configuration are zero, and `res_valid`, `accept`, `reason` and `match_slot` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dst_valid | input | 1 | Address strobe |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| accept | output | 1 | Frame accepted |
| reason | output | 3 | 0 none, 1 slot, 2 broadcast, 3 hash, 4 promiscuous |
| match_slot | output | 2 | Matching slot index when reason is 1 |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the one-cycle timing of `res_valid` and the holding of the verdict between strobes;
- copy-all always winning;
- no-broadcast blocking the all-ones address;
- a zero address never reported as a slot match;
- each hash path staying closed while its enable is clear;
- `accept` agreeing with `reason`.

Other behaviours can only be shown by the bench's scenarios, because each needs a specific register setup: the fold of the hash index (including cancelling bit pairs and indices in the high word), slot priority over the hash, lowest-slot selection, and the all-ones table.

// File: rtl/daf_pkg.sv
package daf_pkg;
    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_SLOT    = 3'd1,
        RSN_BCAST   = 3'd2,
        RSN_HASH    = 3'd3,
        RSN_PROMISC = 3'd4
    } reason_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } fsm_e;

    localparam int CFG_COPY  = 0;
    localparam int CFG_NOBC  = 1;
    localparam int CFG_MHASH = 2;
    localparam int CFG_UHASH = 3;
    localparam int CFG_W     = 4;
endpackage

// File: rtl/daf_hash.sv
module daf_hash #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [HASH_W-1:0] idx
);
    // Fold: index bit (i mod HASH_W) collects address bit i
    always_comb begin
        idx = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            idx[i % HASH_W] = idx[i % HASH_W] ^ addr[i];
        end
    end
endmodule

// File: rtl/daf_slot_bank.sv
module daf_slot_bank #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 48,
    parameter int REG_W   = 32,
    localparam int HI_W   = ADDR_W - REG_W,
    localparam int SL_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SL_W-1:0]   wr_sel,
    input  logic              wr_hi,
    input  logic [REG_W-1:0]  lo_data,
    input  logic [HI_W-1:0]   hi_data,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SL_W-1:0]   hit_idx
);
    logic [N_SLOTS-1:0] hits;

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        logic [REG_W-1:0] lo_q;
        logic [HI_W-1:0]  hi_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_en && wr_sel == SL_W'(k)) begin
                if (wr_hi) hi_q <= hi_data;
                else       lo_q <= lo_data;
            end
        end

        // all-zero slot is unused
        assign hits[k] = ({hi_q, lo_q} != '0) && ({hi_q, lo_q} == addr);
    end

    // lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = N_SLOTS - 1; k >= 0; k--) begin
            if (hits[k]) begin
                hit     = 1'b1;
                hit_idx = SL_W'(k);
            end
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 48,
    parameter int REG_W   = 32,
    parameter int HASH_W  = 6,
    parameter int WA_W    = 4,
    localparam int SL_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              dst_valid,
    output logic              res_valid,
    output logic              accept,
    output logic [2:0]        reason,
    output logic [SL_W-1:0]   match_slot
);
    localparam int HI_W     = ADDR_W - REG_W;
    localparam int HASH_N   = 1 << HASH_W;
    localparam int HASH_WDS = HASH_N / REG_W;
    localparam logic [WA_W-1:0] A_HASH = WA_W'(2 * N_SLOTS);
    localparam logic [WA_W-1:0] A_CFG  = WA_W'(2 * N_SLOTS + HASH_WDS);

    // ---------------- configuration and hash table ----------------
    logic [CFG_W-1:0]  cfg_q;
    logic [HASH_N-1:0] hash_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                        cfg_q <= '0;
        else if (wr_en && wr_addr == A_CFG) cfg_q <= wr_data[CFG_W-1:0];
    end

    for (genvar w = 0; w < HASH_WDS; w++) begin : g_hword
        always_ff @(posedge clk) begin
            if (!rst_n)
                hash_q[w*REG_W +: REG_W] <= '0;
            else if (wr_en && wr_addr == A_HASH + WA_W'(w))
                hash_q[w*REG_W +: REG_W] <= wr_data;
        end
    end

    // ---------------- lookups ----------------
    logic              slot_wr;
    logic              slot_hit;
    logic [SL_W-1:0]   slot_idx;
    logic [HASH_W-1:0] hash_idx;
    logic              hash_bit;

    assign slot_wr = wr_en && (wr_addr < A_HASH);

    daf_slot_bank #(
        .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .REG_W(REG_W)
    ) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (slot_wr),
        .wr_sel  (wr_addr[SL_W:1]),
        .wr_hi   (wr_addr[0]),
        .lo_data (wr_data),
        .hi_data (wr_data[HI_W-1:0]),
        .addr    (dst_addr),
        .hit     (slot_hit),
        .hit_idx (slot_idx)
    );

    daf_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
        .addr (dst_addr),
        .idx  (hash_idx)
    );

    assign hash_bit = hash_q[hash_idx];

    // ---------------- verdict ----------------
    logic            is_bcast, is_mcast;
    logic            dec_acc;
    reason_e         dec_rsn;
    logic [SL_W-1:0] dec_slot;

    assign is_bcast = &dst_addr;
    assign is_mcast = dst_addr[0];

    always_comb begin
        dec_acc  = 1'b0;
        dec_rsn  = RSN_NONE;
        dec_slot = '0;
        if (cfg_q[CFG_COPY]) begin
            dec_acc = 1'b1;
            dec_rsn = RSN_PROMISC;
        end else if (is_bcast) begin
            if (!cfg_q[CFG_NOBC]) begin
                dec_acc = 1'b1;
                dec_rsn = RSN_BCAST;
            end
        end else if (slot_hit) begin
            dec_acc  = 1'b1;
            dec_rsn  = RSN_SLOT;
            dec_slot = slot_idx;
        end else if (hash_bit && (is_mcast ? cfg_q[CFG_MHASH] : cfg_q[CFG_UHASH])) begin
            dec_acc = 1'b1;
            dec_rsn = RSN_HASH;
        end
    end

    // ---------------- state machine ----------------
    fsm_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = dst_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = dst_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    reason_e         rsn_q;
    logic            acc_q;
    logic [SL_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= 1'b0;
            rsn_q  <= RSN_NONE;
            slot_q <= '0;
        end else if (dst_valid) begin
            acc_q  <= dec_acc;
            rsn_q  <= dec_rsn;
            slot_q <= dec_slot;
        end
    end

    assign res_valid  = (state_q == ST_REPORT);
    assign accept     = acc_q;
    assign reason     = rsn_q;
    assign match_slot = slot_q;
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dst_valid,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              res_valid,
    input logic              accept,
    input logic [2:0]        reason,
    input logic              cfg_copy,
    input logic              cfg_nobc,
    input logic              cfg_mh,
    input logic              cfg_uh
);
    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |=> res_valid);

    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |=> !res_valid);

    assert_hold_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |=> ($stable(accept) && $stable(reason)));

    assert_copy_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && cfg_copy) |=> (accept && reason == 3'd4));

    assert_no_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && (&dst_addr) && cfg_nobc && !cfg_copy) |=> !accept);

    assert_zero_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_addr == '0 && !cfg_copy) |=> (reason != 3'd1));

    assert_mhash_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_addr[0] && !cfg_mh) |=> (reason != 3'd3));

    assert_uhash_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_addr[0] && !cfg_uh) |=> (reason != 3'd3));

    assert_accept_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (accept == (reason != 3'd0)));
endmodule

bind dst_addr_filter daf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dst_valid (dst_valid),
    .dst_addr  (dst_addr),
    .res_valid (res_valid),
    .accept    (accept),
    .reason    (reason),
    .cfg_copy  (cfg_q[daf_pkg::CFG_COPY]),
    .cfg_nobc  (cfg_q[daf_pkg::CFG_NOBC]),
    .cfg_mh    (cfg_q[daf_pkg::CFG_MHASH]),
    .cfg_uh    (cfg_q[daf_pkg::CFG_UHASH])
);

// File: tb/dst_addr_filter_test.sv
`timescale 1ns/1ps
module dst_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [47:0] dst_addr = '0;
    logic        dst_valid = 1'b0;
    logic        res_valid, accept;
    logic [2:0]  reason;
    logic [1:0]  match_slot;

    always #4 clk = ~clk;

    dst_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dst_addr(dst_addr), .dst_valid(dst_valid),
        .res_valid(res_valid), .accept(accept), .reason(reason),
        .match_slot(match_slot)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // scoreboard: {accept, reason, slot}
    logic [5:0] exp_q[$];
    string      tag_q[$];

    // shadow of programmed state
    logic [47:0] sh_slot [4];
    logic [63:0] sh_tab;
    logic [3:0]  sh_cfg;

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int i = 0; i < 48; i++) h[i % 6] ^= a[i];
        return h;
    endfunction

    function automatic logic [5:0] model(input logic [47:0] a);
        if (sh_cfg[0]) return {1'b1, 3'd4, 2'd0};
        if (&a) return sh_cfg[1] ? 6'd0 : {1'b1, 3'd2, 2'd0};
        for (int k = 0; k < 4; k++)
            if (sh_slot[k] != '0 && sh_slot[k] == a) return {1'b1, 3'd1, 2'(k)};
        if (sh_tab[hidx(a)] && (a[0] ? sh_cfg[2] : sh_cfg[3])) return {1'b1, 3'd3, 2'd0};
        return 6'd0;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a < 4'd8) begin
            if (a[0]) sh_slot[a[2:1]][47:32] = d[15:0];
            else      sh_slot[a[2:1]][31:0]  = d;
        end else if (a == 4'd8) sh_tab[31:0]  = d;
        else if (a == 4'd9)     sh_tab[63:32] = d;
        else if (a == 4'd10)    sh_cfg = d[3:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_slot(input int k, input logic [47:0] v);
        wr(4'(2*k), v[31:0]);
        wr(4'(2*k+1), {16'd0, v[47:32]});
    endtask

    task automatic set_tab(input logic [63:0] t);
        wr(4'd8, t[31:0]);
        wr(4'd9, t[63:32]);
    endtask

    task automatic push(input logic [47:0] a, input string tag);
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
    endtask

    task automatic probe(input logic [47:0] a, input string tag);
        @(negedge clk);
        dst_valid = 1'b1; dst_addr = a;
        push(a, tag);
        @(negedge clk);
        dst_valid = 1'b0;
    endtask

    // same as probe but with a fixed expectation cross-check
    task automatic probe_exp(input logic [47:0] a, input logic [5:0] e, input string tag);
        total++;
        if (model(a) !== e) begin
            bad++;
            $display("FAIL %s model actual=%h expected=%h", tag, model(a), e);
        end
        probe(a, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R1 unexpected res_valid actual=1 expected=0");
            end else begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({accept, reason, match_slot} !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, {accept, reason, match_slot}, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] UA = 48'hA1B2_C3D4_E5F6;   // unicast
    localparam logic [47:0] UB = 48'h1020_3040_5062;   // unicast
    localparam logic [47:0] MA = 48'h5E00_0001_0001;   // multicast

    initial begin
        for (int k = 0; k < 4; k++) sh_slot[k] = '0;
        sh_tab = '0;
        sh_cfg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        total++;
        if ({res_valid, accept, reason, match_slot} !== 7'd0) begin
            bad++;
            $display("FAIL R11 reset outputs actual=%h expected=0", {res_valid, accept, reason, match_slot});
        end

        probe_exp(BC, {1'b1, 3'd2, 2'd0}, "R4 broadcast default");
        probe_exp(UA, 6'd0, "R10 no match reject");
        probe_exp(48'd0, 6'd0, "R6 zero address unused slots");

        set_slot(2, UA);                              // R2
        probe_exp(UA, {1'b1, 3'd1, 2'd2}, "R5 slot 2 match");
        probe_exp(UA ^ 48'h1_0000_0000, 6'd0, "R5 high byte mismatch");
        set_slot(0, UA);
        probe_exp(UA, {1'b1, 3'd1, 2'd0}, "R5 lowest slot wins");
        set_slot(0, 48'd0);
        probe_exp(48'd0, 6'd0, "R6 cleared slot unused");

        wr(4'd10, 32'h2);                             // no-broadcast
        probe_exp(BC, 6'd0, "R4 no-broadcast reject");
        set_slot(3, BC);
        probe_exp(BC, 6'd0, "R4 broadcast before slot");

        wr(4'd10, 32'h3);                             // copy-all + no-broadcast
        probe_exp(BC, {1'b1, 3'd4, 2'd0}, "R3 copy-all broadcast");
        probe_exp(UB, {1'b1, 3'd4, 2'd0}, "R3 copy-all unicast");

        // hash fold: bits 0 and 5 -> index 33 (high word bit 1)
        wr(4'd10, 32'h4);
        set_tab(64'h0000_0002_0000_0000);
        probe_exp(48'h21, {1'b1, 3'd3, 2'd0}, "R7 index 33 high word");
        probe_exp(48'h03, 6'd0, "R7 index 3 clear");
        set_tab(64'h1);
        probe_exp(48'h41, {1'b1, 3'd3, 2'd0}, "R7 bits 0 and 6 cancel");

        // multicast hash
        set_tab(64'd1 << hidx(MA));
        probe(MA, "R8 multicast hash hit");
        probe(MA ^ 48'h2, "R8 multicast other index");
        wr(4'd10, 32'h0);
        probe(MA, "R8 multicast hash disabled");
        wr(4'd10, 32'h4);
        set_tab('1);
        probe(48'h0102_0304_0507, "R8 all-ones table");
        probe(MA ^ 48'h80_0000, "R8 all-ones table second");

        // unicast hash
        set_tab(64'd1 << hidx(UB));
        probe_exp(UB, 6'd0, "R9 unicast hash disabled");
        wr(4'd10, 32'h8);
        probe_exp(UB, {1'b1, 3'd3, 2'd0}, "R9 unicast hash hit");
        set_slot(1, UB);
        probe_exp(UB, {1'b1, 3'd1, 2'd1}, "R10 slot over hash");

        // R1 back-to-back strobes, then idle
        @(negedge clk);
        dst_valid = 1'b1; dst_addr = UA; push(UA, "R1 back-to-back first");
        @(negedge clk);
        dst_addr = BC; push(BC, "R1 back-to-back second");
        @(negedge clk);
        dst_addr = UB; push(UB, "R1 back-to-back third");
        @(negedge clk);
        dst_valid = 1'b0;
        dst_addr = 48'd0;
        repeat (3) @(negedge clk);
        total++;
        if (res_valid !== 1'b0 || {accept, reason, match_slot} !== {1'b1, 3'd1, 2'd1}) begin
            bad++;
            $display("FAIL R1 idle hold actual=%h expected=%h",
                     {res_valid, accept, reason, match_slot}, {1'b0, 1'b1, 3'd1, 2'd1});
        end

        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R1 missing verdicts actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule